// File: doc/BRIEF.md
# Comparator change interrupt generator

This block takes the outputs of three analog comparators, which change with no relation to the system clock, and turns selected changes into an interrupt request for a microcontroller. Each comparator level is brought into the clock domain through a short flop chain. The settled levels are offered as a three-bit read-only status field, and an interrupt is requested when a watched comparator changes state in either direction.

Software picks the interrupt source through a two-bit enable field, written through a simple write-enable port. One bit watches the second comparator and the other watches the third. Setting both bits does not watch the two separately: the block then watches the exclusive-OR of the two levels, so a change of only one of them interrupts and a change of both in the same sample does not. The first comparator cannot interrupt and is seen only through the status field. The request is a sticky flag that software clears with a one-cycle pulse.

Top module: `cmp_chg_irq`

## Requirements
- R1: `cmp_status` bit 0 shows comparator 1, bit 1 comparator 2 and bit 2 comparator 3. A level change on `cmp_in` shows on `cmp_status` after the second rising clock edge, and not after the first.
- R2: After reset `cmp_status` is 000, `irq` is 0 and the enable field is 00, so no source is selected.
- R3: With enable field 01, a rising or a falling change of comparator 2 sets `irq`. It shows after the third rising edge that follows the input change, and not after the second.
- R4: With enable field 10, a rising or a falling change of comparator 3 sets `irq`.
- R5: With enable field 11, `irq` is set when the XOR of comparators 2 and 3 changes. If both change in the same sample, no interrupt is raised.
- R6: With enable field 00, no comparator change sets `irq`. A change of comparator 1 never sets `irq`, whatever the enable field holds.
- R7: Once set, `irq` stays at 1 until `irq_clr` is high at a rising edge. After that edge `irq` is 0.
- R8: If a selected change and `irq_clr` fall on the same edge, `irq` stays at 1.
- R9: Writing the enable field while the comparator levels are stable never sets `irq`, even if a selected comparator sits at 1.
- R10: The enable field takes `en_wdata` only at an edge where `en_we` is 1. Data presented while `en_we` is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset. Assertion is asynchronous; release is synchronized inside the block |
| cmp_in | input | 3 | Asynchronous comparator outputs. Bit 0 is comparator 1 |
| en_we | input | 1 | Write strobe for the enable field |
| en_wdata | input | 2 | Enable field value. Bit 0 selects comparator 2, bit 1 selects comparator 3, 11 selects their XOR |
| cmp_status | output | 3 | Synchronized comparator levels |
| irq | output | 1 | Sticky interrupt request |
| irq_clr | input | 1 | One-cycle pulse that clears `irq` |

## Verification
The bench builds the block with its default two-stage synchronizer, so the latency edges named in R1 and R3 can be checked as exact cycle counts. Random level vectors under random enable settings cover rising and falling changes for every source mode, including double changes that must cancel in XOR mode. Directed cases place a clear pulse on the same edge as a new change, write the enable field with the strobe low, and write it while a selected comparator is held high.

// File: rtl/cci_pkg.sv
`timescale 1ns/1ps
package cci_pkg;
  // Number of comparator inputs handled by the block.
  localparam int unsigned NUM_CMP = 3;
  // Bit positions of the two comparators that can interrupt.
  localparam int unsigned IDX_C2 = 1;
  localparam int unsigned IDX_C3 = 2;

  // Interrupt source selection, encoded the way the enable field is written.
  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_C2   = 2'b01,
    SRC_C3   = 2'b10,
    SRC_XOR  = 2'b11
  } src_mode_e;
endpackage

// File: rtl/cci_rst_sync.sv
`timescale 1ns/1ps
// Asserts the reset asynchronously and releases it after STAGES clock edges.
module cci_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cci_sync.sv
`timescale 1ns/1ps
// Multi-stage level synchronizer, one chain per bit.
module cci_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign stage_d[s] = d_async;
      end else begin : g_next
        assign stage_d[s] = stage_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/cci_chg_det.sv
`timescale 1ns/1ps
// Keeps the previous synchronized sample and flags a change of the
// source chosen by the enable field.
module cci_chg_det
  import cci_pkg::*;
#(
  parameter int unsigned WIDTH = NUM_CMP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level,
  input  src_mode_e        mode,
  output logic             chg_evt
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] diff;
  logic             xor_now;
  logic             xor_prev;

  // The previous sample follows every cycle, whatever the mode.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;
  end

  always_comb begin
    diff     = level ^ prev_q;
    xor_now  = level[IDX_C2] ^ level[IDX_C3];
    xor_prev = prev_q[IDX_C2] ^ prev_q[IDX_C3];
    unique case (mode)
      SRC_C2:  chg_evt = diff[IDX_C2];
      SRC_C3:  chg_evt = diff[IDX_C3];
      SRC_XOR: chg_evt = xor_now ^ xor_prev;
      default: chg_evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/cmp_chg_irq.sv
`timescale 1ns/1ps
module cmp_chg_irq
  import cci_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   cmp_in,
  input  logic         en_we,
  input  logic [1:0]   en_wdata,
  output logic [2:0]   cmp_status,
  output logic         irq,
  input  logic         irq_clr
);
  localparam int unsigned W = NUM_CMP;

  logic         rst_core_n;
  logic [W-1:0] level;
  logic [1:0]   en_q;
  logic [1:0]   en_d;
  logic         chg_evt;
  logic         irq_q;
  logic         irq_d;

  cci_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  cci_sync #(.WIDTH(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .d_async (cmp_in),
    .q_sync  (level)
  );

  cci_chg_det #(.WIDTH(W)) u_det (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .level   (level),
    .mode    (src_mode_e'(en_q)),
    .chg_evt (chg_evt)
  );

  // Enable field: loaded only with the write strobe.
  always_comb begin
    en_d = en_q;
    if (en_we) en_d = en_wdata;
  end

  // Sticky request: a new change outranks a clear in the same cycle.
  always_comb begin
    irq_d = irq_q;
    if (irq_clr) irq_d = 1'b0;
    if (chg_evt) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      en_q  <= 2'b00;
      irq_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      irq_q <= irq_d;
    end
  end

  assign cmp_status = level;
  assign irq        = irq_q;
endmodule

// File: rtl/cci_chk.sv
`timescale 1ns/1ps
module cci_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] status,
  input logic [1:0] en_q,
  input logic       en_we,
  input logic       irq,
  input logic       irq_clr
);
  logic [2:0] st_d;
  logic       ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_d <= '0;
    else        st_d <= status;
  end

  always_comb begin
    case (en_q)
      2'b01:   ev = status[1] != st_d[1];
      2'b10:   ev = status[2] != st_d[2];
      2'b11:   ev = (status[1] ^ status[2]) != (st_d[1] ^ st_d[2]);
      default: ev = 1'b0;
    endcase
  end

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ev |=> irq); // R3

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !ev) |=> !irq); // R6

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq); // R7

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !ev) |=> !irq); // R7

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_we |=> $stable(en_q)); // R10
endmodule

bind cmp_chg_irq cci_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_core_n),
  .status  (cmp_status),
  .en_q    (en_q),
  .en_we   (en_we),
  .irq     (irq),
  .irq_clr (irq_clr)
);

// File: tb/cmp_chg_irq_test.sv
`timescale 1ns/1ps
module cmp_chg_irq_test;
  logic       clk;
  logic       rst_n;
  logic [2:0] cmp_in;
  logic       en_we;
  logic [1:0] en_wdata;
  logic [2:0] cmp_status;
  logic       irq;
  logic       irq_clr;

  int n_chk;
  int n_fail;

  cmp_chg_irq uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmp_in     (cmp_in),
    .en_we      (en_we),
    .en_wdata   (en_wdata),
    .cmp_status (cmp_status),
    .irq        (irq),
    .irq_clr    (irq_clr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_en(input logic [1:0] v);
    en_we = 1'b1; en_wdata = v;
    step(1);
    en_we = 1'b0;
  endtask

  task automatic pulse_clr();
    irq_clr = 1'b1;
    step(1);
    irq_clr = 1'b0;
  endtask

  // Expected interrupt for a level step from o to n under enable e.
  function automatic bit exp_irq(input logic [2:0] o, input logic [2:0] n, input logic [1:0] e);
    case (e)
      2'b01:   return o[1] ^ n[1];
      2'b10:   return o[2] ^ n[2];
      2'b11:   return (o[1] ^ o[2]) ^ (n[1] ^ n[2]);
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    #1200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [2:0] lv;
    logic [1:0] en;
    void'($urandom(32'd4242));
    rst_n = 1'b0; cmp_in = 3'b000; en_we = 1'b0; en_wdata = 2'b00; irq_clr = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(5);

    // R2: reset state.
    check(cmp_status == 3'b000, "R2 status", cmp_status, 0);
    check(irq == 1'b0, "R2 irq", irq, 0);
    cmp_in = 3'b010; step(4);
    check(irq == 1'b0, "R2 enable reset to 00", irq, 0);

    // R1: bit mapping and two-edge latency.
    cmp_in = 3'b001; step(1);
    check(cmp_status == 3'b010, "R1 after one edge", cmp_status, 2);
    step(1);
    check(cmp_status == 3'b001, "R1 comp1 on bit0", cmp_status, 1);
    cmp_in = 3'b100; step(2);
    check(cmp_status == 3'b100, "R1 comp3 on bit2", cmp_status, 4);

    // R10: data without strobe is ignored.
    en_wdata = 2'b01; step(2);
    cmp_in = 3'b110; step(4);
    check(irq == 1'b0, "R10 write without strobe", irq, 0);

    // R9: enable write with comp2 high and stable.
    wr_en(2'b01); step(4);
    check(irq == 1'b0, "R9 enable write no irq", irq, 0);

    // R3: falling comp2, latency three edges.
    cmp_in = 3'b100; step(2);
    check(irq == 1'b0, "R3 not after two edges", irq, 0);
    step(1);
    check(irq == 1'b1, "R3 falling comp2", irq, 1);

    // R7: sticky, then cleared.
    step(10);
    check(irq == 1'b1, "R7 sticky hold", irq, 1);
    pulse_clr();
    check(irq == 1'b0, "R7 cleared", irq, 0);

    // R8: change and clear on the same edge.
    cmp_in = 3'b110; step(3);
    check(irq == 1'b1, "R3 rising comp2", irq, 1);
    cmp_in = 3'b100; step(2);
    irq_clr = 1'b1; step(1); irq_clr = 1'b0;
    check(irq == 1'b1, "R8 set wins over clear", irq, 1);
    pulse_clr();
    check(irq == 1'b0, "R8 later clear", irq, 0);

    // R6: comp1 never interrupts.
    cmp_in = 3'b101; step(4);
    check(irq == 1'b0, "R6 comp1 ignored", irq, 0);

    // R5: XOR mode, both change together -> none; one changes -> irq.
    wr_en(2'b11); step(2);
    cmp_in = 3'b011; step(4);
    check(irq == 1'b0, "R5 double change cancels", irq, 0);
    cmp_in = 3'b001; step(4);
    check(irq == 1'b1, "R5 single change", irq, 1);
    pulse_clr();

    // R4: comp3 mode.
    wr_en(2'b10); step(2);
    cmp_in = 3'b101; step(4);
    check(irq == 1'b1, "R4 rising comp3", irq, 1);
    pulse_clr();

    // Random phase against the expectation function.
    lv = 3'b101;
    for (int i = 0; i < 400; i++) begin
      logic [2:0] nv;
      en = 2'($urandom);
      wr_en(en); step(2);
      pulse_clr();
      check(irq == 1'b0, "R9 random enable write", irq, 0);
      nv = 3'($urandom);
      cmp_in = nv; step(4);
      check(cmp_status == nv, "R1 random status", cmp_status, nv);
      if (en == 2'b00)      check(irq == 1'b0, "R6 random off", irq, 0);
      else if (en == 2'b01) check(irq == exp_irq(lv, nv, en), "R3 random comp2", irq, exp_irq(lv, nv, en));
      else if (en == 2'b10) check(irq == exp_irq(lv, nv, en), "R4 random comp3", irq, exp_irq(lv, nv, en));
      else                  check(irq == exp_irq(lv, nv, en), "R5 random xor", irq, exp_irq(lv, nv, en));
      lv = nv;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule